// File: doc/BRIEF.md
# Fractional Bit-Clock Divider

This block derives a serial-audio bit clock from a fast reference clock. The divisor is a whole part of up to 10 bits plus a fraction in 1/512 steps. The result is then halved, because each divisor period produces one half period of the output. The average output frequency is f_ref / 2 / (W + F/512), where W is the whole part and F is the fraction. This lets a single reference serve sample rates from a few kilohertz up to about 192 kHz. The usual target is 2 × sample width × sample rate, which carries two channels per frame.

A 9-bit phase accumulator adds F once per half period. Every wrap of the accumulator stretches the following half period by one reference cycle. The output toggles only at half-period boundaries, and new divisor values take effect only there, so reprogramming never produces a runt pulse. The output stays low in three cases: the enable bit is clear, the block is in slave mode (the bit clock then comes from outside), or W is zero. One-cycle rise and fall strobes accompany each change of the output, so downstream serialisers can run in the reference clock domain.

Top module: `fbclk_divider`

## Requirements
- R1: While reset is asserted and right after it, `bclk`, `bclk_rise` and `bclk_fall` are 0.
- R2: With `clk_en` low, `bclk` is 0 from the first cycle after the clock edge that samples it, and it does not toggle.
- R3: With `slave_mode` high, `bclk` is held at 0 and no strobes are produced, whatever the divisor and enable inputs are.
- R4: A whole divisor `div_whole` of 0 holds `bclk` at 0 with no strobes.
- R5: Starting from the stopped state, the first edge that samples the divider as active loads the divisor. The first low half then lasts `div_whole` cycles, so `bclk` rises `div_whole`+1 cycles after the input change is sampled.
- R6: With `div_frac` = 0, every half period lasts exactly `div_whole` reference cycles.
- R7: Any 512 consecutive half periods with constant inputs last exactly 512·`div_whole` + `div_frac` reference cycles in total.
- R8: Each single half period lasts either `div_whole` or `div_whole`+1 cycles. It is never longer than `div_whole` when `div_frac` is 0.
- R9: Changing `div_whole` or `div_frac` in the middle of a half period leaves the length of that half period unchanged. The new value sets the length of the next half period.
- R10: `bclk_rise` is 1 for exactly the cycles in which `bclk` has just changed from 0 to 1. `bclk_fall` is 1 for exactly the cycles in which it has just changed from 1 to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| div_whole | input | 10 | Whole part of the half-period divisor, in reference cycles |
| div_frac | input | 9 | Fractional part of the divisor, in 1/512 cycle units |
| clk_en | input | 1 | Enable; low stops the divider and holds the output low |
| slave_mode | input | 1 | High when the bit clock is supplied externally; the divider stays idle |
| bclk | output | 1 | Generated bit clock level |
| bclk_rise | output | 1 | One-cycle strobe in the cycle `bclk` has just risen |
| bclk_fall | output | 1 | One-cycle strobe in the cycle `bclk` has just fallen |

## Verification
The divider is run with whole divisors from 1 to 7, with fractions of zero, one, half and nearly one unit, and with uneven fractions. The total length of 512 half periods then shows whether the accumulator adds exactly `div_frac` extra cycles. The shortest and longest half periods show whether any single stretch exceeds one cycle. Zero-fraction vectors separate plain integer division from any stray carry. Directed runs cover start-up latency, the three ways of stopping the output, and a divisor change made mid half period, which tells latching at the boundary apart from immediate use.

// File: rtl/fbclk_pkg.sv
package fbclk_pkg;

    // Output phase of the divider; the bit clock level is HIGH phase.
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_LOW  = 2'd1,
        PH_HIGH = 2'd2
    } fbclk_phase_e;

endpackage

// File: rtl/fbclk_gate.sv
// Decides whether the divider may run in this cycle.
module fbclk_gate #(
    parameter int WHOLE_W = 10
) (
    input  logic               clk_en,
    input  logic               slave_mode,
    input  logic [WHOLE_W-1:0] div_whole,
    output logic               run_ok
);
    logic whole_nonzero;

    always_comb begin
        whole_nonzero = |div_whole;
        run_ok        = clk_en && !slave_mode && whole_nonzero;
    end
endmodule

// File: rtl/fbclk_frac_step.sv
// One step of the fractional phase accumulator: adds the fraction and
// reports a wrap, which stretches the next half period by one cycle.
module fbclk_frac_step #(
    parameter int FRAC_W = 9
) (
    input  logic [FRAC_W-1:0] acc_in,
    input  logic [FRAC_W-1:0] frac_in,
    output logic [FRAC_W-1:0] acc_out,
    output logic              wrap
);
    localparam int SUM_W = FRAC_W + 1;

    logic [SUM_W-1:0] sum;

    always_comb begin
        sum     = {1'b0, acc_in} + {1'b0, frac_in};
        acc_out = sum[FRAC_W-1:0];
        wrap    = sum[FRAC_W];
    end
endmodule

// File: rtl/fbclk_half_len.sv
// Reload value of the half-period counter: (whole + wrap) - 1.
// Only used while whole is nonzero, so the result cannot underflow.
module fbclk_half_len #(
    parameter int WHOLE_W = 10
) (
    input  logic [WHOLE_W-1:0] whole_in,
    input  logic               wrap,
    output logic [WHOLE_W-1:0] load_val
);
    localparam int EXT_W = WHOLE_W + 1;

    logic [EXT_W-1:0] ext_len;
    logic [EXT_W-1:0] ext_m1;

    always_comb begin
        ext_len  = {1'b0, whole_in} + {{WHOLE_W{1'b0}}, wrap};
        ext_m1   = ext_len - {{WHOLE_W{1'b0}}, 1'b1};
        load_val = ext_m1[WHOLE_W-1:0];
    end
endmodule

// File: rtl/fbclk_divider.sv
module fbclk_divider
    import fbclk_pkg::*;
#(
    parameter int WHOLE_W = 10,
    parameter int FRAC_W  = 9
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [WHOLE_W-1:0] div_whole,
    input  logic [FRAC_W-1:0]  div_frac,
    input  logic               clk_en,
    input  logic               slave_mode,
    output logic               bclk,
    output logic               bclk_rise,
    output logic               bclk_fall
);
    // Half-period counter needs (2^WHOLE_W - 1) + 1 - 1 as largest load.
    localparam int CNT_W = WHOLE_W;
    localparam logic [CNT_W-1:0] CNT_ZERO = '0;
    localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

    typedef struct packed {
        fbclk_phase_e      phase;
        logic [CNT_W-1:0]  cnt;
        logic [FRAC_W-1:0] acc;
        logic              rise;
        logic              fall;
    } div_state_t;

    div_state_t st_q, st_d;

    logic              run_ok;
    logic [FRAC_W-1:0] step_acc_in;
    logic [FRAC_W-1:0] step_acc_out;
    logic              step_wrap;
    logic [CNT_W-1:0]  reload_val;
    logic              at_boundary;

    fbclk_gate #(.WHOLE_W(WHOLE_W)) u_gate (
        .clk_en     (clk_en),
        .slave_mode (slave_mode),
        .div_whole  (div_whole),
        .run_ok     (run_ok)
    );

    // A fresh start begins the accumulator from zero.
    always_comb begin
        step_acc_in = (st_q.phase == PH_IDLE) ? '0 : st_q.acc;
        at_boundary = (st_q.phase != PH_IDLE) && (st_q.cnt == CNT_ZERO);
    end

    fbclk_frac_step #(.FRAC_W(FRAC_W)) u_step (
        .acc_in  (step_acc_in),
        .frac_in (div_frac),
        .acc_out (step_acc_out),
        .wrap    (step_wrap)
    );

    fbclk_half_len #(.WHOLE_W(WHOLE_W)) u_len (
        .whole_in (div_whole),
        .wrap     (step_wrap),
        .load_val (reload_val)
    );

    always_comb begin
        st_d      = st_q;
        st_d.rise = 1'b0;
        st_d.fall = 1'b0;
        if (!run_ok) begin
            st_d.phase = PH_IDLE;
            st_d.cnt   = '0;
            st_d.acc   = '0;
            st_d.fall  = (st_q.phase == PH_HIGH);
        end else if (st_q.phase == PH_IDLE) begin
            // Start: divisor sampled here, first half period is low.
            st_d.phase = PH_LOW;
            st_d.acc   = step_acc_out;
            st_d.cnt   = reload_val;
        end else if (at_boundary) begin
            // Half-period boundary: toggle and take the current divisor.
            st_d.phase = (st_q.phase == PH_LOW) ? PH_HIGH : PH_LOW;
            st_d.rise  = (st_q.phase == PH_LOW);
            st_d.fall  = (st_q.phase == PH_HIGH);
            st_d.acc   = step_acc_out;
            st_d.cnt   = reload_val;
        end else begin
            st_d.cnt   = st_q.cnt - CNT_ONE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{phase: PH_IDLE, cnt: '0, acc: '0, rise: 1'b0, fall: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign bclk      = (st_q.phase == PH_HIGH);
    assign bclk_rise = st_q.rise;
    assign bclk_fall = st_q.fall;

    // ---------------- assertions ----------------
    AST_STOP_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (!clk_en || slave_mode || (div_whole == '0)) |=> !bclk && !bclk_rise) // R2
        else $error("output not held low while stopped");

    AST_SLAVE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        slave_mode |=> (st_q.phase == PH_IDLE)) // R3
        else $error("divider ran in slave mode");

    AST_MID_HALF_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (run_ok && st_q.phase != PH_IDLE && st_q.cnt != CNT_ZERO)
            |=> $stable(bclk) && (st_q.cnt == $past(st_q.cnt) - CNT_ONE)) // R9
        else $error("half period disturbed before its boundary");

    AST_RISE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bclk) |-> bclk_rise) // R10
        else $error("rise strobe missing");

    AST_FALL_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bclk) |-> bclk_fall) // R10
        else $error("fall strobe missing");

    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({bclk_rise, bclk_fall})) // R10
        else $error("both strobes at once");

endmodule

// File: tb/fbclk_divider_test.sv
module fbclk_divider_test;

    localparam int WW = 10;
    localparam int FW = 9;
    localparam int NVEC = 8;
    localparam int HALVES = 512;
    localparam int WATCHDOG = 190000;

    // Stimulus table: whole part and fraction; expectations follow R6-R8.
    localparam int V_WHOLE [NVEC] = '{1, 1, 2, 3, 4, 5, 7, 2};
    localparam int V_FRAC  [NVEC] = '{0, 256, 1, 511, 0, 100, 300, 383};

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [WW-1:0] div_whole = '0;
    logic [FW-1:0] div_frac = '0;
    logic          clk_en = 1'b0;
    logic          slave_mode = 1'b0;
    logic          bclk, bclk_rise, bclk_fall;

    int n_checks = 0;
    int n_fail = 0;
    int cycles = 0;
    bit done = 1'b0;

    fbclk_divider #(.WHOLE_W(WW), .FRAC_W(FW)) uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .div_whole  (div_whole),
        .div_frac   (div_frac),
        .clk_en     (clk_en),
        .slave_mode (slave_mode),
        .bclk       (bclk),
        .bclk_rise  (bclk_rise),
        .bclk_fall  (bclk_fall)
    );

    always #4 clk = ~clk;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > WATCHDOG && !done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected below %0d", cycles, WATCHDOG);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Waits for a toggle, then times the next 'halves' half periods.
    task automatic measure(input int halves, output int total, output int mn,
                           output int mx, output int strobe_bad);
        logic prev, last;
        int guard, len;
        total = 0; mn = 1 << 20; mx = 0; strobe_bad = 0;
        guard = 0;
        prev = bclk;
        do begin
            @(negedge clk);
            guard++;
        end while (bclk == prev && guard < 5000);
        last = bclk;
        for (int h = 0; h < halves; h++) begin
            len = 0;
            prev = bclk;
            do begin
                @(negedge clk);
                len++;
                if (bclk_rise != (bclk && !last)) strobe_bad++;
                if (bclk_fall != (!bclk && last)) strobe_bad++;
                last = bclk;
            end while (bclk == prev && len < 5000);
            total += len;
            if (len < mn) mn = len;
            if (len > mx) mx = len;
        end
    endtask

    task automatic count_activity(input int n, output int highs, output int strobes);
        highs = 0; strobes = 0;
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            if (bclk) highs++;
            if (bclk_rise || bclk_fall) strobes++;
        end
    endtask

    initial begin
        int total, mn, mx, sbad, highs, strobes, lat, len;
        logic prev;

        // R1: reset state
        repeat (4) @(negedge clk);
        check(bclk == 1'b0 && bclk_rise == 1'b0 && bclk_fall == 1'b0, "R1 in reset",
              {bclk, bclk_rise, bclk_fall}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(bclk == 1'b0, "R1 after reset", bclk, 0);

        // Table walk: R6, R7, R8, R10, then stop via R2
        for (int i = 0; i < NVEC; i++) begin
            @(negedge clk);
            div_whole = WW'(V_WHOLE[i]);
            div_frac  = FW'(V_FRAC[i]);
            clk_en    = 1'b1;
            measure(HALVES, total, mn, mx, sbad);
            check(total == HALVES * V_WHOLE[i] + V_FRAC[i], "R7 total of 512 halves",
                  total, HALVES * V_WHOLE[i] + V_FRAC[i]);
            check(mn >= V_WHOLE[i] && mx <= V_WHOLE[i] + ((V_FRAC[i] != 0) ? 1 : 0),
                  "R8 half period range", mx * 10000 + mn,
                  (V_WHOLE[i] + ((V_FRAC[i] != 0) ? 1 : 0)) * 10000 + V_WHOLE[i]);
            if (V_FRAC[i] == 0)
                check(mn == V_WHOLE[i] && mx == V_WHOLE[i], "R6 integer halves",
                      mx, V_WHOLE[i]);
            check(sbad == 0, "R10 strobes follow edges", sbad, 0);
            clk_en = 1'b0;
            @(negedge clk);
            check(bclk == 1'b0, "R2 low after disable", bclk, 0);
        end

        // R5: start-up latency
        @(negedge clk);
        div_whole = 10'd6;
        div_frac  = 9'd0;
        clk_en    = 1'b1;
        lat = 0;
        do begin
            @(negedge clk);
            lat++;
        end while (!bclk && lat < 100);
        check(lat == 7, "R5 first rise latency", lat, 7);

        // R2: enable cleared keeps output quiet
        clk_en = 1'b0;
        count_activity(100, highs, strobes);
        check(highs == 0, "R2 no high while disabled", highs, 0);

        // R3: slave mode
        div_whole  = 10'd4;
        clk_en     = 1'b1;
        slave_mode = 1'b1;
        count_activity(100, highs, strobes);
        check(highs == 0 && strobes == 0, "R3 slave mode quiet", highs + strobes, 0);

        // R4: zero whole divisor
        slave_mode = 1'b0;
        div_whole  = 10'd0;
        div_frac   = 9'd200;
        count_activity(100, highs, strobes);
        check(highs == 0 && strobes == 0, "R4 zero divisor quiet", highs + strobes, 0);

        // R9: change divisor in mid half period
        div_whole = 10'd20;
        div_frac  = 9'd0;
        measure(0, total, mn, mx, sbad);
        len = 0;
        prev = bclk;
        do begin
            @(negedge clk);
            len++;
            if (len == 5) div_whole = 10'd3;
        end while (bclk == prev && len < 100);
        check(len == 20, "R9 running half keeps old length", len, 20);
        mn = 0; mx = 0; total = 0;
        for (int h = 0; h < 4; h++) begin
            int l2;
            l2 = 0;
            prev = bclk;
            do begin
                @(negedge clk);
                l2++;
            end while (bclk == prev && l2 < 100);
            check(l2 == 3, "R9 next halves use new value", l2, 3);
        end

        // R10: disabling while high yields a fall strobe
        do @(negedge clk); while (!bclk);
        clk_en = 1'b0;
        @(negedge clk);
        check(bclk == 1'b0 && bclk_fall == 1'b1, "R10 fall strobe on stop",
              {bclk, bclk_fall}, 1);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

endmodule